// File: doc/BRIEF.md
# Departure-Time Layer Scheduler for a Parallel Packet Switch

This block is the central scheduler of a switch whose buffering is spread over several slower, identical switching layers. An arriving cell must be placed on one layer. Its input link to that layer must be free, and the layer's link to the destination output must be free in the slot when the cell is due to leave. For each output the scheduler tracks two things: the next slot in which that output has nothing scheduled, and how long each layer's link to that output stays busy as seen from that slot. It grants the lowest-numbered layer that is free on both sides. The departure slot it returns is the one in which a first-come-first-served output-queued switch would send the same cell.

One request per input may arrive in each slot (one clock is one slot). A request carries the destination output and a mask of the layers that the input can reach in this slot. The input side tracks that mask; this block does not. Requests within a slot are served in ascending input order, so any number of them may aim at the same output. Each grant carries the layer, the departure slot and a per-output sequence tag that counts the cells granted for that output.

Top module: `pps_layer_sched`

## Requirements
- R1: While `rst_n` is low, `gnt_valid`, `gnt_err` and `slot` are all zero. After reset every output is idle, no layer is busy and every tag count is zero.
- R2: A granted layer has its bit set in the request's mask (bit l of an input's mask field stands for layer l). No cell is granted to that output in the WIN-1 slots before its departure slot on that layer.
- R3: When several layers qualify, the lowest-numbered one is granted.
- R4: The departure slot is the later of the output's next free slot and the slot in which the request arrived. Each grant for an output moves that output's next free slot forward by one.
- R5: A layer granted for output o with departure slot D is not granted again for o with departure slots D+1 to D+WIN-1. It may be granted again for slot D+WIN.
- R6: Requests presented in the same slot are served in ascending input index. Each later request sees the state left by the earlier ones, including those for the same output.
- R7: Tags count grants per output, starting at 1 for the first grant after reset. Each output counts independently. The count wraps modulo 2^TAG_W.
- R8: If no layer qualifies, `gnt_err` is raised for that input instead of `gnt_valid`. The output's next free slot, layer windows and tag are left unchanged.
- R9: The response to a request presented in a slot appears on the outputs one clock later. `slot` increases by one on every clock after reset.
- R10: An output whose next free slot has fallen behind the current slot is first brought up to the current slot. Layer windows that ended in the meantime count as expired.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one slot per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | N_IN | Request present, one bit per input |
| req_out | input | N_IN*OUT_W | Destination output per input, input i in bits [i*OUT_W +: OUT_W] |
| req_mask | input | N_IN*LAYERS | Input-side free layers per input, input i in bits [i*LAYERS +: LAYERS] |
| slot | output | TIME_W | Current slot number |
| gnt_valid | output | N_IN | Grant issued for the request of the previous slot |
| gnt_err | output | N_IN | No layer available for the request of the previous slot |
| gnt_layer | output | N_IN*LYR_W | Granted layer per input |
| gnt_time | output | N_IN*TIME_W | Departure slot per input |
| gnt_tag | output | N_IN*TAG_W | Per-output sequence tag per input |

## Verification
The first pattern is a lone request with a full mask. It shows the idle-output case, where the departure slot equals the arrival slot, apart from the lowest-layer choice. The second is a burst in which every input targets one output in the same slot. This separates correct in-order serving and window rolling from a design that reuses a layer too early or reads stale state. Narrow and empty masks separate the intersection rule and error handling from a design that grants outside the mask. Idle gaps followed by long random traffic test catching up to a lagging departure index and tag wrap, using a behavioural model that stores start slots rather than countdowns.

// File: rtl/pps_layer_sched.sv
module pps_layer_sched #(
  parameter int N_IN   = 4,
  parameter int N_OUT  = 4,
  parameter int LAYERS = 4,
  parameter int WIN    = 3,
  parameter int TIME_W = 16,
  parameter int TAG_W  = 8,
  localparam int OUT_W = (N_OUT > 1) ? $clog2(N_OUT) : 1,
  localparam int LYR_W = (LAYERS > 1) ? $clog2(LAYERS) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_IN-1:0]         req_valid,
  input  logic [N_IN*OUT_W-1:0]   req_out,
  input  logic [N_IN*LAYERS-1:0]  req_mask,
  output logic [TIME_W-1:0]       slot,
  output logic [N_IN-1:0]         gnt_valid,
  output logic [N_IN-1:0]         gnt_err,
  output logic [N_IN*LYR_W-1:0]   gnt_layer,
  output logic [N_IN*TIME_W-1:0]  gnt_time,
  output logic [N_IN*TAG_W-1:0]   gnt_tag
);
  localparam int CNT_W = $clog2(WIN + 1);
  localparam int PAD   = TIME_W - CNT_W;

  logic [TIME_W-1:0] slot_q;
  logic [TIME_W-1:0] dt_q [N_OUT];
  logic [TIME_W-1:0] dt_n [N_OUT];
  logic [CNT_W-1:0]  cnt_q [N_OUT][LAYERS];
  logic [CNT_W-1:0]  cnt_n [N_OUT][LAYERS];
  logic [TAG_W-1:0]  tag_q [N_OUT];
  logic [TAG_W-1:0]  tag_n [N_OUT];

  logic [N_IN-1:0]   gv_n, ge_n, gv_q, ge_q;
  logic [LYR_W-1:0]  gl_n [N_IN];
  logic [LYR_W-1:0]  gl_q [N_IN];
  logic [TIME_W-1:0] gt_n [N_IN];
  logic [TIME_W-1:0] gt_q [N_IN];
  logic [TAG_W-1:0]  gg_n [N_IN];
  logic [TAG_W-1:0]  gg_q [N_IN];

  always_comb begin : p_sched
    logic [OUT_W-1:0]  o;
    logic [LAYERS-1:0] avail;
    logic [LYR_W-1:0]  sel;
    logic [TIME_W-1:0] lag;
    for (int q = 0; q < N_OUT; q++) begin
      lag = slot_q - dt_q[q];
      tag_n[q] = tag_q[q];
      if (lag != '0 && !lag[TIME_W-1]) begin
        dt_n[q] = slot_q;
        for (int l = 0; l < LAYERS; l++)
          cnt_n[q][l] = ({{PAD{1'b0}}, cnt_q[q][l]} <= lag) ? '0 : cnt_q[q][l] - CNT_W'(lag);
      end else begin
        dt_n[q] = dt_q[q];
        for (int l = 0; l < LAYERS; l++) cnt_n[q][l] = cnt_q[q][l];
      end
    end
    for (int i = 0; i < N_IN; i++) begin
      gv_n[i] = 1'b0;
      ge_n[i] = 1'b0;
      gl_n[i] = '0;
      gt_n[i] = '0;
      gg_n[i] = '0;
      o = req_out[i*OUT_W +: OUT_W];
      avail = '0;
      sel = '0;
      if (req_valid[i]) begin
        if (int'(o) < N_OUT)
          for (int l = 0; l < LAYERS; l++)
            avail[l] = req_mask[i*LAYERS + l] && (cnt_n[o][l] == '0);
        for (int l = LAYERS - 1; l >= 0; l--)
          if (avail[l]) sel = LYR_W'(l);
        if (avail == '0) begin
          ge_n[i] = 1'b1;
        end else begin
          gv_n[i] = 1'b1;
          gl_n[i] = sel;
          gt_n[i] = dt_n[o];
          tag_n[o] = tag_n[o] + TAG_W'(1);
          gg_n[i] = tag_n[o];
          dt_n[o] = dt_n[o] + TIME_W'(1);
          for (int l = 0; l < LAYERS; l++)
            if (cnt_n[o][l] != '0) cnt_n[o][l] = cnt_n[o][l] - CNT_W'(1);
          cnt_n[o][sel] = CNT_W'(WIN - 1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_q <= '0;
      gv_q   <= '0;
      ge_q   <= '0;
      for (int q = 0; q < N_OUT; q++) begin
        dt_q[q]  <= '0;
        tag_q[q] <= '0;
        for (int l = 0; l < LAYERS; l++) cnt_q[q][l] <= '0;
      end
      for (int i = 0; i < N_IN; i++) begin
        gl_q[i] <= '0;
        gt_q[i] <= '0;
        gg_q[i] <= '0;
      end
    end else begin
      slot_q <= slot_q + TIME_W'(1);
      gv_q   <= gv_n;
      ge_q   <= ge_n;
      dt_q   <= dt_n;
      tag_q  <= tag_n;
      cnt_q  <= cnt_n;
      gl_q   <= gl_n;
      gt_q   <= gt_n;
      gg_q   <= gg_n;
    end
  end

  assign slot      = slot_q;
  assign gnt_valid = gv_q;
  assign gnt_err   = ge_q;

  for (genvar i = 0; i < N_IN; i++) begin : g_flat
    assign gnt_layer[i*LYR_W +: LYR_W]   = gl_q[i];
    assign gnt_time[i*TIME_W +: TIME_W]  = gt_q[i];
    assign gnt_tag[i*TAG_W +: TAG_W]     = gg_q[i];
  end
endmodule

// File: rtl/pps_layer_sched_chk.sv
module pps_layer_sched_chk #(
  parameter int N_IN   = 4,
  parameter int N_OUT  = 4,
  parameter int LAYERS = 4,
  parameter int WIN    = 3,
  parameter int TIME_W = 16,
  parameter int TAG_W  = 8,
  localparam int OUT_W = (N_OUT > 1) ? $clog2(N_OUT) : 1,
  localparam int LYR_W = (LAYERS > 1) ? $clog2(LAYERS) : 1
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [N_IN-1:0]         req_valid,
  input logic [N_IN*OUT_W-1:0]   req_out,
  input logic [N_IN*LAYERS-1:0]  req_mask,
  input logic [TIME_W-1:0]       slot,
  input logic [N_IN-1:0]         gnt_valid,
  input logic [N_IN-1:0]         gnt_err,
  input logic [N_IN*LYR_W-1:0]   gnt_layer,
  input logic [N_IN*TIME_W-1:0]  gnt_time,
  input logic [N_IN*TAG_W-1:0]   gnt_tag
);
  logic [N_IN*LAYERS-1:0] mask_q;
  logic [TIME_W-1:0]      slot_prev;
  always_ff @(posedge clk) begin
    mask_q    <= req_mask;
    slot_prev <= slot;
  end

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (gnt_valid == '0 && gnt_err == '0 && slot == '0));

  a_r9_slot_step: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (slot == $past(slot) + TIME_W'(1)));

  for (genvar i = 0; i < N_IN; i++) begin : g_chk
    logic [LYR_W-1:0]  lyr;
    logic [TIME_W-1:0] ahead;
    assign lyr   = gnt_layer[i*LYR_W +: LYR_W];
    assign ahead = gnt_time[i*TIME_W +: TIME_W] - slot_prev;

    a_r2_layer_in_mask: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_valid[i] |-> mask_q[i*LAYERS + int'(lyr)]);

    a_r8_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(gnt_valid[i] && gnt_err[i]));

    a_r9_resp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_valid[i] || gnt_err[i]) |-> $past(req_valid[i]));

    a_r4_not_before_arrival: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_valid[i] |-> !ahead[TIME_W-1]);
  end
endmodule

bind pps_layer_sched pps_layer_sched_chk #(
  .N_IN(N_IN), .N_OUT(N_OUT), .LAYERS(LAYERS), .WIN(WIN), .TIME_W(TIME_W), .TAG_W(TAG_W)
) u_chk (.*);

// File: tb/tb_pps_layer_sched.sv
module tb_pps_layer_sched;
  localparam int N_IN = 4, N_OUT = 4, LAYERS = 4, WIN = 3, TIME_W = 16, TAG_W = 8;
  localparam int OUT_W = 2, LYR_W = 2;

  logic clk = 0, rst_n = 0;
  logic [N_IN-1:0] req_valid = '0;
  logic [N_IN*OUT_W-1:0] req_out = '0;
  logic [N_IN*LAYERS-1:0] req_mask = '0;
  logic [TIME_W-1:0] slot;
  logic [N_IN-1:0] gnt_valid, gnt_err;
  logic [N_IN*LYR_W-1:0] gnt_layer;
  logic [N_IN*TIME_W-1:0] gnt_time;
  logic [N_IN*TAG_W-1:0] gnt_tag;

  always #5 clk = ~clk;

  pps_layer_sched dut (.*);

  int errors = 0, checks = 0;
  int mslot;
  int mdt [N_OUT];
  int mtag [N_OUT];
  int mlast [N_OUT][LAYERS];
  bit ev [N_IN];
  bit ee [N_IN];
  int el [N_IN], et [N_IN], eg [N_IN];
  bit rv [N_IN];
  int ro [N_IN];
  logic [LAYERS-1:0] rm [N_IN];

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at slot %0d", req, act, exp, mslot);
    end
  endtask

  task automatic model();
    for (int i = 0; i < N_IN; i++) begin
      ev[i] = 0; ee[i] = 0; el[i] = 0; et[i] = 0; eg[i] = 0;
      if (rv[i]) begin
        int o, pick;
        o = ro[i];
        if (mdt[o] < mslot) mdt[o] = mslot;
        pick = -1;
        for (int l = LAYERS - 1; l >= 0; l--)
          if (rm[i][l] && (mdt[o] - mlast[o][l] >= WIN)) pick = l;
        if (pick < 0) ee[i] = 1;
        else begin
          ev[i] = 1; el[i] = pick; et[i] = mdt[o] % 65536;
          mtag[o]++; eg[i] = mtag[o] % 256;
          mlast[o][pick] = mdt[o];
          mdt[o]++;
        end
      end
    end
  endtask

  task automatic step();
    @(negedge clk);
    mslot++;
    check("R9 slot", int'(slot), mslot % 65536);
    for (int i = 0; i < N_IN; i++) begin
      check("R9/R2 valid", int'(gnt_valid[i]), int'(ev[i]));
      check("R8 err", int'(gnt_err[i]), int'(ee[i]));
      if (ev[i]) begin
        check("R2/R3 layer", int'(gnt_layer[i*LYR_W +: LYR_W]), el[i]);
        check("R4 time", int'(gnt_time[i*TIME_W +: TIME_W]), et[i]);
        check("R7 tag", int'(gnt_tag[i*TAG_W +: TAG_W]), eg[i]);
      end
    end
    for (int i = 0; i < N_IN; i++) begin
      req_valid[i] = rv[i];
      req_out[i*OUT_W +: OUT_W] = OUT_W'(ro[i]);
      req_mask[i*LAYERS +: LAYERS] = rm[i];
    end
    model();
  endtask

  task automatic idle_req();
    for (int i = 0; i < N_IN; i++) begin rv[i] = 0; ro[i] = 0; rm[i] = '0; end
  endtask

  initial begin
    #(200000 * 10);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int o = 0; o < N_OUT; o++) begin
      mdt[o] = 0; mtag[o] = 0;
      for (int l = 0; l < LAYERS; l++) mlast[o][l] = -1000000;
    end
    for (int i = 0; i < N_IN; i++) ev[i] = 0;
    for (int i = 0; i < N_IN; i++) ee[i] = 0;
    idle_req();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: quiet outputs under reset
    check("R1 valid", int'(gnt_valid), 0);
    check("R1 err", int'(gnt_err), 0);
    check("R1 slot", int'(slot), 0);
    rst_n = 1;
    mslot = 0;
    step();
    // R2/R3/R4: lone request, idle output, full mask
    rv[0] = 1; ro[0] = 0; rm[0] = 4'hF;
    step(); idle_req();
    // R2/R3: narrow mask
    rv[1] = 1; ro[1] = 2; rm[1] = 4'b0110;
    step(); idle_req();
    // R5/R6: all inputs to one output in one slot
    for (int i = 0; i < N_IN; i++) begin rv[i] = 1; ro[i] = 3; rm[i] = 4'hF; end
    step();
    for (int i = 0; i < N_IN; i++) begin rv[i] = 1; ro[i] = 3; rm[i] = 4'b0011; end
    step(); idle_req();
    // R8: empty mask, then same output shows no change
    rv[2] = 1; ro[2] = 1; rm[2] = 4'h0;
    step(); idle_req();
    rv[2] = 1; ro[2] = 1; rm[2] = 4'h1;
    step(); idle_req();
    // R10: idle gap lets the output fall behind the slot
    repeat (12) step();
    rv[3] = 1; ro[3] = 3; rm[3] = 4'hF;
    step(); idle_req();
    // R7 wrap, R5/R6 mixes: random traffic
    for (int n = 0; n < 3000; n++) begin
      for (int i = 0; i < N_IN; i++) begin
        rv[i] = ($urandom_range(0, 9) < 7);
        ro[i] = $urandom_range(0, N_OUT - 1);
        rm[i] = ($urandom_range(0, 7) == 0) ? 4'h0 : LAYERS'($urandom_range(1, 15));
      end
      step();
    end
    idle_req();
    step(); step();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule